// File: doc/BRIEF.md
# Doppler-Offset NCO Clock Generator

This block synthesizes a square clock from a much faster system clock. The method is a wide phase accumulator whose top bit is the generated clock. The accumulator adds a frequency word on every system cycle, so that word alone sets the output frequency. The word is the sum of a fixed nominal increment and a small signed offset. The offset models a Doppler shift of a few hertz around a 1 MHz carrier.

The offset never jumps to a new command. A commanded target is first limited to a programmable magnitude. The applied offset then walks toward that target by at most one slew step per update tick. It lands exactly on the target and never overshoots, so the output frequency drifts smoothly. With a 48-bit accumulator, one increment LSB is a tiny fraction of a ppm of a 1 MHz output. This gives many more than 50 steps on each side of nominal. The edges of the output are tied to the system clock, so they jitter by up to one system period.

Top module: `doppler_nco`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the accumulator and the applied offset. On the cycle after that edge, `clk_out` is 0 and `applied_inc` equals `nominal_inc`.
- R2: `applied_inc` always equals `nominal_inc` plus the applied offset. The offset is sign-extended to ACC_W bits and the sum wraps modulo 2^ACC_W.
- R3: On every clock edge out of reset, the accumulator adds the `applied_inc` value present before that edge, modulo 2^ACC_W. `clk_out` is the accumulator's most significant bit after the edge.
- R4: The applied offset changes only on update ticks. Ticks fall on the edges numbered TICK_DIV-1, 2*TICK_DIV-1, and so on, counting from 0 at the first edge with `rst` low. At all other edges `applied_inc` holds if `nominal_inc` holds.
- R5: At a tick, let d be the clamped target minus the applied offset. If |d| is at most `slew_step`, the offset becomes the clamped target. Otherwise the offset moves by `slew_step` toward the target, so it never overshoots.
- R6: The target is clamped to the range [-`ofs_limit`, +`ofs_limit`]. `target_ofs` is a two's complement value and `ofs_limit` is unsigned.
- R7: When `slew_step` is 0, a tick leaves the offset unchanged.
- R8: A change to `target_ofs` or `slew_step` that is present at a tick edge takes effect at that same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, far faster than the output |
| rst | input | 1 | Synchronous active-high reset |
| nominal_inc | input | ACC_W | Phase increment for the nominal output frequency |
| target_ofs | input | OFS_W | Signed commanded Doppler offset, in increment LSBs |
| slew_step | input | OFS_W | Unsigned largest offset change per update tick |
| ofs_limit | input | OFS_W | Unsigned largest allowed offset magnitude |
| clk_out | output | 1 | Generated clock (accumulator MSB) |
| applied_inc | output | ACC_W | Increment currently added each cycle |

## Verification
Two events can fall on the same edge: a new target or step command arriving, and an update tick. A third case is the slewer landing on a target that was just clamped by a changed limit. The bench varies the time between command changes so that they do not repeat on a multiple of TICK_DIV. Changes therefore land on every tick phase, and one phase places a change on the exact edge of a tick. An arithmetic model of clamp, slew and accumulation judges every cycle. In that model, whatever is present at the tick edge wins.

// File: rtl/dnco_pkg.sv
package dnco_pkg;
   // Decision taken by the slewer at an update tick
   typedef enum logic [1:0] {
      SLEW_HOLD = 2'd0,
      SLEW_UP   = 2'd1,
      SLEW_DOWN = 2'd2,
      SLEW_LAND = 2'd3
   } slew_op_t;

   localparam int unsigned DEF_ACC_W    = 48;
   localparam int unsigned DEF_OFS_W    = 24;
   localparam int unsigned DEF_TICK_DIV = 1000;
endpackage

// File: rtl/dnco_clamp.sv
module dnco_clamp #(
   parameter int unsigned OFS_W = 24
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OFS_W-1:0] target,
   input  logic [OFS_W-1:0] limit,
   output logic [OFS_W-1:0] clamped
);
   logic signed [OFS_W:0] tgt_x, lim_pos, lim_neg, res_x;

   always_comb begin
      tgt_x   = $signed({target[OFS_W-1], target});
      lim_pos = $signed({1'b0, limit});
      lim_neg = -lim_pos;
      if (tgt_x > lim_pos)      res_x = lim_pos;
      else if (tgt_x < lim_neg) res_x = lim_neg;
      else                      res_x = tgt_x;
      clamped = res_x[OFS_W-1:0];
   end

   logic signed [OFS_W:0] out_x;
   assign out_x = $signed({clamped[OFS_W-1], clamped});

   // R6
   clamp_range_chk: assert property (@(posedge clk) disable iff (rst)
      (out_x <= $signed({1'b0, limit})) && (out_x >= -$signed({1'b0, limit})));
endmodule

// File: rtl/dnco_slew.sv
module dnco_slew
   import dnco_pkg::*;
#(
   parameter int unsigned OFS_W    = 24,
   parameter int unsigned TICK_DIV = 1000
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OFS_W-1:0] target,
   input  logic [OFS_W-1:0] step,
   output logic [OFS_W-1:0] ofs
);
   localparam int unsigned CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam int unsigned EXT_W = OFS_W + 2;

   logic tick;

   generate
      if (TICK_DIV == 1) begin : g_tick_every
         assign tick = 1'b1;
      end else begin : g_tick_div
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst)                                   cnt <= '0;
            else if (cnt == CNT_W'(TICK_DIV - 1))      cnt <= '0;
            else                                       cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == CNT_W'(TICK_DIV - 1));

         // R4
         tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
            tick |=> !tick);
      end
   endgenerate

   logic signed [EXT_W-1:0] ofs_x, tgt_x, step_x, diff;
   slew_op_t                op;
   logic [OFS_W-1:0]        ofs_nxt;

   always_comb begin
      ofs_x  = $signed({{2{ofs[OFS_W-1]}}, ofs});
      tgt_x  = $signed({{2{target[OFS_W-1]}}, target});
      step_x = $signed({2'b00, step});
      diff   = tgt_x - ofs_x;
      if (!tick || step == '0 || diff == '0) op = SLEW_HOLD;
      else if (diff > 0 && diff <= step_x)   op = SLEW_LAND;
      else if (diff < 0 && -diff <= step_x)  op = SLEW_LAND;
      else if (diff > 0)                     op = SLEW_UP;
      else                                   op = SLEW_DOWN;
      case (op)
         SLEW_LAND: ofs_nxt = target;
         SLEW_UP:   ofs_nxt = ofs + step;
         SLEW_DOWN: ofs_nxt = ofs - step;
         default:   ofs_nxt = ofs;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) ofs <= '0;
      else     ofs <= ofs_nxt;
   end

   // R1
   ofs_reset_chk: assert property (@(posedge clk) rst |=> (ofs == '0));

   // R4
   ofs_tick_only_chk: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(ofs));

   // R5
   slew_bound_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((ofs_x - $past(ofs_x)) <= $past(step_x)) &&
               (($past(ofs_x) - ofs_x) <= $past(step_x)));

   // R5
   no_overshoot_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (($past(ofs_x) <= $past(tgt_x)) ?
                  (ofs_x >= $past(ofs_x) && ofs_x <= $past(tgt_x)) :
                  (ofs_x <= $past(ofs_x) && ofs_x >= $past(tgt_x))));

   // R7
   zero_step_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (step == '0) |=> $stable(ofs));
endmodule

// File: rtl/dnco_phase_acc.sv
module dnco_phase_acc #(
   parameter int unsigned ACC_W = 48
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] inc,
   output logic             clk_out
);
   logic [ACC_W-1:0] acc;

   always_ff @(posedge clk) begin
      if (rst) acc <= '0;
      else     acc <= acc + inc;
   end

   assign clk_out = acc[ACC_W-1];

   // R1
   acc_reset_chk: assert property (@(posedge clk) rst |=> !clk_out);

   // R3
   rise_needs_carry_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(clk_out) && !$past(inc[ACC_W-1])) |->
         (({1'b0, $past(acc[ACC_W-2:0])} + {1'b0, $past(inc[ACC_W-2:0])}) >= {1'b1, {(ACC_W-1){1'b0}}}));
endmodule

// File: rtl/doppler_nco.sv
module doppler_nco
   import dnco_pkg::*;
#(
   parameter int unsigned ACC_W    = DEF_ACC_W,
   parameter int unsigned OFS_W    = DEF_OFS_W,
   parameter int unsigned TICK_DIV = DEF_TICK_DIV
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] nominal_inc,
   input  logic [OFS_W-1:0] target_ofs,
   input  logic [OFS_W-1:0] slew_step,
   input  logic [OFS_W-1:0] ofs_limit,
   output logic             clk_out,
   output logic [ACC_W-1:0] applied_inc
);
   localparam int unsigned SEXT_W = ACC_W - OFS_W;

   generate
      if (ACC_W < 4) begin : g_bad_acc
         $error("doppler_nco: ACC_W must be at least 4");
      end
      if (OFS_W < 2 || OFS_W >= ACC_W) begin : g_bad_ofs
         $error("doppler_nco: OFS_W must be in [2, ACC_W-1]");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("doppler_nco: TICK_DIV must be at least 1");
      end
   endgenerate

   logic [OFS_W-1:0] tgt_clamped;
   logic [OFS_W-1:0] ofs_now;

   dnco_clamp #(.OFS_W(OFS_W)) u_clamp (
      .clk     (clk),
      .rst     (rst),
      .target  (target_ofs),
      .limit   (ofs_limit),
      .clamped (tgt_clamped)
   );

   dnco_slew #(.OFS_W(OFS_W), .TICK_DIV(TICK_DIV)) u_slew (
      .clk    (clk),
      .rst    (rst),
      .target (tgt_clamped),
      .step   (slew_step),
      .ofs    (ofs_now)
   );

   assign applied_inc = nominal_inc + {{SEXT_W{ofs_now[OFS_W-1]}}, ofs_now};

   dnco_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .inc     (applied_inc),
      .clk_out (clk_out)
   );
endmodule

// File: tb/doppler_nco_bench.sv
module doppler_nco_bench;
   localparam int ACC_W = 16;
   localparam int OFS_W = 8;
   localparam int DIV   = 3;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [ACC_W-1:0] nominal_inc = 16'h0800;
   logic [OFS_W-1:0] target_ofs  = '0;
   logic [OFS_W-1:0] slew_step   = 8'd1;
   logic [OFS_W-1:0] ofs_limit   = 8'd127;
   logic             clk_out;
   logic [ACC_W-1:0] applied_inc;

   doppler_nco #(.ACC_W(ACC_W), .OFS_W(OFS_W), .TICK_DIV(DIV)) u_doppler_nco (
      .clk(clk), .rst(rst), .nominal_inc(nominal_inc), .target_ofs(target_ofs),
      .slew_step(slew_step), .ofs_limit(ofs_limit),
      .clk_out(clk_out), .applied_inc(applied_inc)
   );

   always #2 clk = ~clk;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   logic [ACC_W-1:0] m_acc = '0;
   int               m_ofs = 0;
   int               m_k   = 0;

   function automatic int clamp_tgt();
      int t, l;
      t = int'($signed(target_ofs));
      l = int'(ofs_limit);
      if (t > l)  t = l;
      if (t < -l) t = -l;
      return t;
   endfunction

   // one clock edge: model predicts, then outputs are compared at the falling edge
   task automatic cyc(input string ptag);
      bit               was_tick;
      int               t, d, s;
      logic [ACC_W-1:0] exp_inc;
      string            tag;
      was_tick = 0;
      if (rst) begin
         m_acc = '0; m_ofs = 0; m_k = 0;
      end else begin
         m_acc = m_acc + nominal_inc + ACC_W'(m_ofs);
         if ((m_k % DIV) == DIV - 1) begin
            was_tick = 1;
            t = clamp_tgt();
            d = t - m_ofs;
            s = int'(slew_step);
            if (s != 0) begin
               if (d <= s && d >= -s) m_ofs = t;
               else if (d > 0)        m_ofs = m_ofs + s;
               else                   m_ofs = m_ofs - s;
            end
         end
         m_k++;
      end
      tag = rst ? "R1" : (was_tick ? ptag : "R4");
      @(posedge clk);
      @(negedge clk);
      exp_inc = nominal_inc + ACC_W'(m_ofs);
      n_run++;
      if (applied_inc !== exp_inc) begin
         n_fail++;
         $display("FAIL %s applied_inc actual=%h expected=%h", tag, applied_inc, exp_inc);
      end
      n_run++;
      if (clk_out !== m_acc[ACC_W-1]) begin
         n_fail++;
         $display("FAIL %s clk_out actual=%b expected=%b", rst ? "R1" : "R3",
                  clk_out, m_acc[ACC_W-1]);
      end
   endtask

   task automatic run(input int n, input string ptag);
      for (int i = 0; i < n; i++) cyc(ptag);
   endtask

   initial begin
      @(negedge clk);
      run(3, "R1");
      rst = 1'b0;
      // R4: first tick comes on edge DIV-1 after release
      target_ofs = 8'd40; slew_step = 8'd10;
      run(20, "R4");
      // R5/R6 near-exhaustive sweep; 61-cycle runs shift command changes across tick phases
      foreach (ofs_limit_set[li]) begin
         ofs_limit = ofs_limit_set[li];
         foreach (step_set[si]) begin
            slew_step = step_set[si];
            for (int tv = -128; tv < 128; tv += 17) begin
               target_ofs = OFS_W'(tv);
               run(61, (int'(ofs_limit) < 127) ? "R6" : "R5");
            end
         end
      end
      // R7: zero step holds whatever offset is applied
      ofs_limit = 8'd127; target_ofs = 8'd90; slew_step = 8'd0;
      run(30, "R7");
      // R8: command change placed exactly on the tick edge
      slew_step = 8'd5;
      for (int j = 0; j < 12; j++) begin
         while ((m_k % DIV) != DIV - 1) cyc("R8");
         target_ofs = (j % 2 == 0) ? 8'd100 : 8'hA0;
         slew_step  = 8'(3 + j);
         cyc("R8");
      end
      // R2: sum wraps modulo 2^ACC_W both ways
      nominal_inc = 16'hFFFA; target_ofs = 8'd20; slew_step = 8'd255;
      run(40, "R2");
      nominal_inc = 16'h0003; target_ofs = 8'hF0;
      run(40, "R2");
      // R1: reset in mid-run with a nonzero offset
      nominal_inc = 16'h0800;
      rst = 1'b1;
      run(2, "R1");
      rst = 1'b0;
      run(10, "R4");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   logic [OFS_W-1:0] ofs_limit_set [4] = '{8'd0, 8'd5, 8'd100, 8'd127};
   logic [OFS_W-1:0] step_set      [4] = '{8'd1, 8'd4, 8'd37, 8'd255};

   initial begin
      #800000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule